// File: doc/BRIEF.md
# Audio Transmit Sample Queue with Interrupt Logic

This block is the register front end of a stereo audio transmitter. A processor reaches it through a simple 32-bit read/write port. Through that port it sets the serializer configuration, chooses which interrupt causes are enabled, and reads and clears interrupt status. It also pushes audio samples into a deep queue of 32-bit words. Each stereo frame is two words, written left first and then right, through the first data port.

A downstream serializer pulls words through a show-ahead pop interface. It also receives the configuration fields as plain outputs. Two conditions are derived from the queue occupancy. The underrun condition means the queue is empty. The low-level condition means the occupancy is under a threshold, which is the queue depth divided by a power of two chosen by a 4-bit field. Both conditions are latched into a status register that software clears by writing ones. The interrupt line combines status, mask and a global enable.

The queue depth is a parameter. The full-size build uses 2^13 words, and the default is smaller so that elaboration stays cheap.

Top module: `atx_tx_front`

## Requirements
- R1: After reset, the configuration and mask registers read 0, the queue is empty (`pop_valid` low) and `irq` is low.
- R2: The identity register at byte offset 0x00 reads the `VERSION` parameter, and writes to it have no effect. Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled.
- R3: The configuration register at offset 0x04 stores only the bits in mask 0xFF3FFF07, and other bits read 0. Bit 0 drives `tx_enable`, bit 1 is the interrupt enable, bit 2 drives `left_first`, bits 15:8 drive `clk_ratio`, bits 21:16 drive `sample_res`, bits 27:24 select the level threshold and bits 31:28 drive `chan_sel`.
- R4: The mask register at offset 0x08 stores bits 1:0, and all other bits read 0.
- R5: Status bit 0 (underrun) at offset 0x0C is set in every cycle that follows a cycle with an empty queue. It stays set after the queue refills, until it is cleared.
- R6: Status bit 1 (low level) is set whenever the occupancy is less than DEPTH shifted right by the level field. Level 0 therefore means "not full", and a shift that reaches zero never sets the bit.
- R7: Writing a 1 to a status bit clears it. The bit sets again on the next cycle while its condition still holds. Writing 0 leaves the bit unchanged.
- R8: `irq` equals the interrupt enable (configuration bit 1) AND the OR of (status AND mask).
- R9: Words written to offset 0x10 leave the queue on `pop_data` in write order. `pop_data` shows the oldest word while `pop_valid` is high, and `pop_req` removes it.
- R10: A data write while the queue holds DEPTH words is dropped, and the stored words are unchanged.
- R11: Writes to offsets 0x14, 0x18 and 0x1C, and any access with nonzero low address bits, have no effect. Reads of offsets 0x10 to 0x1C return 0.
- R12: `pop_req` while the queue is empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pop_req | input | 1 | Remove the oldest queued word |
| pop_valid | output | 1 | Queue not empty |
| pop_data | output | 32 | Oldest queued word |
| tx_enable | output | 1 | Transmit enable field |
| left_first | output | 1 | Left flag field |
| clk_ratio | output | 8 | Clock ratio field |
| sample_res | output | 6 | Sample resolution field |
| chan_sel | output | 4 | Channel field |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses a 16-word queue and sweeps every fill level from empty to full against level shifts 0 to 6. This catches a threshold that is off by one, or one that shifts the wrong way, because such a design reports low level at the wrong occupancy, including at full and at a zero threshold. The bench overfills the queue and then drains it, so a design that overwrote the oldest word or advanced its write pointer when full would return a wrong word. It pops an empty queue and then pushes, so a pointer that slipped on an empty pop shows up as stale data. Status is checked for stickiness after a refill, for reassertion while the queue is still empty, and for immunity to zero writes. Every mask, enable and status combination is then compared against the interrupt line.

// File: rtl/atx_pkg.sv
package atx_pkg;

    // word index decoded from bus_addr[4:2]
    localparam logic [2:0] IDX_VER  = 3'd0;
    localparam logic [2:0] IDX_CFG  = 3'd1;
    localparam logic [2:0] IDX_MASK = 3'd2;
    localparam logic [2:0] IDX_STAT = 3'd3;
    localparam logic [2:0] IDX_DAT0 = 3'd4;

    localparam logic [31:0] CFG_WMASK = 32'hFF3F_FF07;

    localparam int ST_W     = 2;
    localparam int ST_UNDER = 0;
    localparam int ST_LOW   = 1;

    // field positions are software visible
    typedef struct packed {
        logic [3:0] chan;
        logic [3:0] level;
        logic [1:0] pad_hi;
        logic [5:0] res;
        logic [7:0] ratio;
        logic [4:0] pad_lo;
        logic       left;
        logic       int_en;
        logic       tx_en;
    } cfg_t;

endpackage

// File: rtl/atx_fifo.sv
module atx_fifo #(
    parameter int DW         = 32,
    parameter int DEPTH_LOG2 = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic [DW-1:0]         push_data,
    input  logic                  pop,
    output logic [DW-1:0]         head,
    output logic [DEPTH_LOG2:0]   count
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam int CW    = DEPTH_LOG2 + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH_LOG2-1:0] wp;
        logic [DEPTH_LOG2-1:0] rp;
        logic [CW-1:0]         cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        do_push = push && (st_q.cnt != FULL_CNT);
        do_pop  = pop && (st_q.cnt != '0);
        st_d    = st_q;
        if (do_push) st_d.wp = st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = st_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= push_data;
    end

    assign head  = mem_q[st_q.rp];
    assign count = st_q.cnt;

    // R10: occupancy never exceeds the depth
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);
    // R10: a push into a full queue without a pop leaves the count alone
    a_r10_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && st_q.cnt == FULL_CNT) |=> st_q.cnt == $past(st_q.cnt));
    // R12: popping an empty queue keeps it empty
    a_r12_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q.cnt == '0) |=> st_q.cnt == '0);

endmodule

// File: rtl/atx_status.sv
module atx_status
    import atx_pkg::*;
#(
    parameter int DEPTH_LOG2 = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DEPTH_LOG2:0] fifo_cnt,
    input  logic [3:0]          level_sel,
    input  logic                clr_en,
    input  logic [ST_W-1:0]     clr_bits,
    input  logic [ST_W-1:0]     mask,
    input  logic                int_en,
    output logic [ST_W-1:0]     status,
    output logic                irq
);
    localparam int CW = DEPTH_LOG2 + 1;
    localparam logic [CW-1:0] DEPTH_CNT = CW'(1 << DEPTH_LOG2);

    logic [CW-1:0]   thr;
    logic [ST_W-1:0] cond;
    logic [ST_W-1:0] st_d, st_q;

    always_comb begin
        thr            = DEPTH_CNT >> level_sel;
        cond           = '0;
        cond[ST_UNDER] = (fifo_cnt == '0);
        cond[ST_LOW]   = (fifo_cnt < thr);
        st_d           = (st_q & ~(clr_en ? clr_bits : '0)) | cond;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q;
    assign irq    = int_en && |(st_q & mask);

    // R5: an empty queue shows up as underrun on the next cycle
    a_r5_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == '0) |=> status[ST_UNDER]);
    // R6: occupancy under the threshold shows up as low level
    a_r6_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt < thr) |=> status[ST_LOW]);
    // R7: a clear with a non-empty queue drops the underrun bit
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_bits[ST_UNDER] && fifo_cnt != '0) |=> !status[ST_UNDER]);

endmodule

// File: rtl/atx_tx_front.sv
module atx_tx_front
    import atx_pkg::*;
#(
    parameter int          DEPTH_LOG2 = 11,
    parameter logic [31:0] VERSION    = 32'h0002_0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        pop_req,
    output logic        pop_valid,
    output logic [31:0] pop_data,
    output logic        tx_enable,
    output logic        left_first,
    output logic [7:0]  clk_ratio,
    output logic [5:0]  sample_res,
    output logic [3:0]  chan_sel,
    output logic        irq
);
    typedef struct packed {
        cfg_t            cfg;
        logic [ST_W-1:0] mask;
        logic [31:0]     rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0]          idx;
    logic                aligned;
    logic                wr_hit, rd_hit;
    logic                push;
    logic                clr_en;
    logic [DEPTH_LOG2:0] fifo_cnt;
    logic [ST_W-1:0]     status;

    always_comb begin
        idx     = bus_addr[4:2];
        aligned = (bus_addr[1:0] == 2'b00);
        wr_hit  = bus_wr && aligned;
        rd_hit  = bus_rd && aligned;
        push    = wr_hit && (idx == IDX_DAT0);
        clr_en  = wr_hit && (idx == IDX_STAT);

        r_d = r_q;
        if (wr_hit && idx == IDX_CFG)  r_d.cfg  = cfg_t'(bus_wdata & CFG_WMASK);
        if (wr_hit && idx == IDX_MASK) r_d.mask = bus_wdata[ST_W-1:0];

        if (bus_rd) begin
            r_d.rdata = '0;
            if (rd_hit) begin
                case (idx)
                    IDX_VER:  r_d.rdata = VERSION;
                    IDX_CFG:  r_d.rdata = 32'(r_q.cfg);
                    IDX_MASK: r_d.rdata = 32'(r_q.mask);
                    IDX_STAT: r_d.rdata = 32'(status);
                    default:  r_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    atx_fifo #(
        .DW         (32),
        .DEPTH_LOG2 (DEPTH_LOG2)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (bus_wdata),
        .pop       (pop_req),
        .head      (pop_data),
        .count     (fifo_cnt)
    );

    atx_status #(
        .DEPTH_LOG2 (DEPTH_LOG2)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_cnt  (fifo_cnt),
        .level_sel (r_q.cfg.level),
        .clr_en    (clr_en),
        .clr_bits  (bus_wdata[ST_W-1:0]),
        .mask      (r_q.mask),
        .int_en    (r_q.cfg.int_en),
        .status    (status),
        .irq       (irq)
    );

    assign bus_rdata  = r_q.rdata;
    assign pop_valid  = (fifo_cnt != '0);
    assign tx_enable  = r_q.cfg.tx_en;
    assign left_first = r_q.cfg.left;
    assign clk_ratio  = r_q.cfg.ratio;
    assign sample_res = r_q.cfg.res;
    assign chan_sel   = r_q.cfg.chan;

    // R2: an aligned identity read returns the constant next cycle
    a_r2_version_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 5'h00) |=> bus_rdata == VERSION);
    // R11: data-port reads return zero
    a_r11_data_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[4]) |=> bus_rdata == '0);
    // R8: no interrupt while nothing is masked in
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mask == '0) |-> !irq);

endmodule

// File: tb/atx_tx_front_bench.sv
`timescale 1ns/1ps
module atx_tx_front_bench;
    localparam int          DL2   = 4;
    localparam int          DEPTH = 1 << DL2;
    localparam logic [31:0] VER   = 32'h0002_0100;
    localparam logic [31:0] WMSK  = 32'hFF3F_FF07;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, pop_req = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, pop_data;
    logic        pop_valid, tx_enable, left_first, irq;
    logic [7:0]  clk_ratio;
    logic [5:0]  sample_res;
    logic [3:0]  chan_sel;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    atx_tx_front #(.DEPTH_LOG2(DL2), .VERSION(VER)) u_atx_tx_front (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
        .tx_enable(tx_enable), .left_first(left_first), .clk_ratio(clk_ratio),
        .sample_res(sample_res), .chan_sel(chan_sel), .irq(irq));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pop(output logic v, output logic [31:0] d);
        @(negedge clk);
        v = pop_valid; d = pop_data; pop_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pop_req = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic        v;
        logic [31:0] pats [3];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_A5A5; pats[2] = 32'h1234_5678;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pop_valid", 32'(pop_valid), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(5'h04, d); chk("R1 cfg", d, 0);
        rd(5'h08, d); chk("R1 mask", d, 0);

        // R2 identity register
        rd(5'h00, d); chk("R2 version", d, VER);
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, d); chk("R2 version after write", d, VER);

        // R3 config storage and field outputs
        foreach (pats[i]) begin
            wr(5'h04, pats[i]);
            rd(5'h04, d); chk("R3 cfg readback", d, pats[i] & WMSK);
            chk("R3 tx_enable", 32'(tx_enable), 32'(pats[i][0]));
            chk("R3 left_first", 32'(left_first), 32'(pats[i][2]));
            chk("R3 clk_ratio", 32'(clk_ratio), 32'(pats[i][15:8]));
            chk("R3 sample_res", 32'(sample_res), 32'(pats[i][21:16]));
            chk("R3 chan_sel", 32'(chan_sel), 32'(pats[i][31:28]));
        end
        // R11 misaligned write ignored
        wr(5'h05, 32'h0000_0000);
        rd(5'h04, d); chk("R11 misaligned write", d, pats[2] & WMSK);
        wr(5'h04, 0);

        // R4 mask register
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, d); chk("R4 mask all ones", d, 32'h3);
        wr(5'h08, 0);
        rd(5'h08, d); chk("R4 mask zero", d, 0);

        // R5 R6 sweep of fill level against every level shift
        for (int k = 0; k <= DEPTH; k++) begin
            for (int lvl = 0; lvl <= 6; lvl++) begin
                int thr;
                thr = DEPTH >> lvl;
                wr(5'h04, 32'(lvl) << 24);
                wr(5'h0C, 32'h3);
                idle(2);
                rd(5'h0C, d);
                chk("R6 low-level bit", 32'(d[1]), 32'(k < thr));
                chk("R5 underrun bit", 32'(d[0]), 32'(k == 0));
            end
            if (k < DEPTH) wr(5'h10, 32'hC000_0000 + 32'(k));
        end

        // R10 write while full is dropped
        wr(5'h10, 32'hDEAD_BEEF);
        // R9 drain in order
        for (int i = 0; i < DEPTH; i++) begin
            pop(v, d);
            chk("R9 pop_valid", 32'(v), 1);
            chk("R9 order", d, 32'hC000_0000 + 32'(i));
        end
        @(negedge clk);
        chk("R10 empty after drain", 32'(pop_valid), 0);

        // R12 pop while empty then push
        pop(v, d);
        wr(5'h10, 32'h0000_5A5A);
        @(negedge clk);
        chk("R12 valid after push", 32'(pop_valid), 1);
        chk("R12 head intact", pop_data, 32'h0000_5A5A);
        pop(v, d);

        // R5 latch after refill; R7 zero write, clear, reassert
        wr(5'h04, 32'h0F00_0000);
        idle(2);
        wr(5'h10, 32'h0000_0001);
        idle(2);
        rd(5'h0C, d); chk("R5 underrun sticky", 32'(d[0]), 1);
        wr(5'h0C, 0);
        idle(2);
        rd(5'h0C, d); chk("R7 zero write keeps", 32'(d[0]), 1);
        wr(5'h0C, 32'h1);
        idle(2);
        rd(5'h0C, d); chk("R7 clear", 32'(d[0]), 0);
        pop(v, d);
        wr(5'h0C, 32'h1);
        idle(2);
        rd(5'h0C, d); chk("R7 reassert while empty", 32'(d[0]), 1);

        // R8 interrupt combinations over three status states
        for (int s = 0; s < 3; s++) begin
            logic [1:0] st;
            if (s == 1) wr(5'h10, 32'h1);
            for (int en = 0; en < 2; en++) begin
                for (int m = 0; m < 4; m++) begin
                    wr(5'h04, ((s == 2) ? 32'h0 : 32'h0F00_0000) | (32'(en) << 1));
                    wr(5'h0C, 32'h3);
                    wr(5'h08, 32'(m));
                    idle(2);
                    st = (s == 0) ? 2'b01 : (s == 1) ? 2'b00 : 2'b10;
                    @(negedge clk);
                    chk("R8 irq", 32'(irq), 32'((en == 1) && ((st & 2'(m)) != 0)));
                end
            end
        end
        wr(5'h04, 0);
        wr(5'h08, 0);
        pop(v, d);
        idle(2);

        // R11 other data ports ignored, data reads zero
        wr(5'h14, 32'h1); wr(5'h18, 32'h2); wr(5'h1C, 32'h3);
        idle(2);
        @(negedge clk);
        chk("R11 other ports no push", 32'(pop_valid), 0);
        rd(5'h10, d); chk("R11 data read zero", d, 0);
        rd(5'h1C, d); chk("R11 last port read zero", d, 0);

        finish_run();
    end
endmodule